// File: doc/BRIEF.md
# NAND Bus Width Adapter

This block sits between a simple CPU register bus and a NAND flash bus. Each of eight chip-select windows holds three registers: a command register, an address register and a data register. A CPU access to one of them becomes a short run of device transfers on the NAND side. Each transfer is 8 or 16 bits wide, as the per-window width field sets. Command and address writes mark their transfers with the command-latch or address-latch strobe. Data transfers carry neither strobe. On a read, the bytes or halfwords that come back are packed into the CPU word with the lowest part first.

The CPU side holds its request steady until the adapter returns a one-cycle ready pulse. That pulse comes only after the last device transfer has been accepted, so a wide access to a narrow device simply stalls the CPU for longer. The NAND side uses a valid/ready handshake. The device model may hold off any transfer, and the adapter keeps every field of that transfer stable until it is taken. Accesses that produce no transfers still complete, one cycle after they are accepted, and a read of that kind returns zero.

Top module: `nand_width_adapter`

## Requirements
- R1: Window n (0 to 7) places its command register at byte address 0x60 + 0x30*n + 0x1C, its address register at +0x20 and its data register at +0x24. The two lowest address bits do not select anything. An access to any other address causes no NAND transfer, and a read there returns 0.
- R2: NAND transfers take place only when the window's 2-bit device-type field equals 2. For any other value, writes cause no transfer and data reads return 0.
- R3: The window's 2-bit width field selects the device: 0 for an 8-bit device, 1 for a 16-bit device. A value of 2 or 3 causes no transfer, and reads return 0.
- R4: Transfers caused by the command register have nandCle=1 and nandAle=0. Transfers caused by the address register have nandAle=1 and nandCle=0. Data-register transfers have both at 0.
- R5: On an 8-bit device the access size (reqSize 0=8, 1=16, 2 or 3=32 bits) gives 1, 2 or 4 byte transfers. Byte k of the CPU word goes out in transfer k on nandWdata[7:0], with nandWdata[15:8]=0. On a read, nandRdata[7:0] of transfer k becomes read bits 8k+7:8k.
- R6: On a 16-bit device a 32-bit access gives two halfword transfers, the lower half first, and a 16-bit access gives one. Read halfword k of the word comes from transfer k.
- R7: An 8-bit access to a 16-bit device gives one 16-bit transfer carrying reqWdata[15:0]. A read of that kind returns all 16 device bits in rspRdata[15:0].
- R8: reqReady stays low until every transfer of the access has been handshaken, then goes high for exactly one cycle. The pulse comes one cycle after the last handshake, or one cycle after acceptance if the access has no transfers. While nandValid is high and nandReady is low, all NAND outputs hold.
- R9: Reads of the command or address register cause no transfer and return 0.
- R10: During a transfer, nandCs gives the window index, nandWrite gives the access direction, and nandWide is 1 exactly for a 16-bit device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | CPU access request, held until reqReady |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte address of the access |
| reqSize | input | 2 | 0 = 8, 1 = 16, 2/3 = 32 bits |
| reqWdata | input | 32 | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read data, valid with reqReady |
| csDevType | input | 16 | Device-type field, 2 bits per window |
| csWidth | input | 16 | Width field, 2 bits per window |
| nandValid | output | 1 | Transfer valid |
| nandReady | input | 1 | Device accepts the transfer |
| nandCs | output | 3 | Window index of the transfer |
| nandCle | output | 1 | Command latch strobe |
| nandAle | output | 1 | Address latch strobe |
| nandWrite | output | 1 | Transfer direction |
| nandWide | output | 1 | 16-bit transfer |
| nandWdata | output | 16 | Transfer write data |
| nandRdata | input | 16 | Device read data, taken at the handshake |

## Verification
An access is accepted at the first clock edge after it is presented. The first transfer is valid in the next cycle, and each transfer completes at the edge where nandReady is high. reqReady and rspRdata are due in the cycle after the final handshake, or in the cycle after acceptance when no transfer is planned. The bench drives and samples only at falling edges. It sets nandReady and nandRdata before deciding whether a transfer is being taken at the coming edge. It counts falling edges from the request, so with nandReady held high the completion latency is checked exactly as transfers plus one.

// File: rtl/nwa_pkg.sv
package nwa_pkg;
  localparam int DATA_W     = 32;
  localparam int MAX_BEATS  = 4;
  localparam int BEAT_IDX_W = $clog2(MAX_BEATS);
  localparam int BEAT_CNT_W = BEAT_IDX_W + 1;

  localparam logic [1:0] DEV_NAND = 2'd2;
  localparam logic [1:0] WID_8    = 2'd0;
  localparam logic [1:0] WID_16   = 2'd1;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} accSize_e;
  typedef enum logic [1:0] {REG_NONE, REG_CMD, REG_ADR, REG_DAT} regKind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} ctrlState_e;

  typedef struct packed {
    logic [BEAT_CNT_W-1:0] beats;
    logic                  cle;
    logic                  ale;
    logic                  wide;
  } accPlan_t;

  typedef struct packed {
    logic                  load;
    logic                  beatDone;
    logic                  wide;
    logic [BEAT_IDX_W-1:0] beatIdx;
  } dpStrobe_t;
endpackage

// File: rtl/nwa_decode.sv
module nwa_decode
  import nwa_pkg::*;
#(
  parameter int NUM_CS     = 8,
  parameter int ADDR_W     = 12,
  parameter int WIN_BASE   = 'h60,
  parameter int WIN_STRIDE = 'h30,
  parameter int CMD_OFS    = 'h1C,
  parameter int ADR_OFS    = 'h20,
  parameter int DAT_OFS    = 'h24
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [1:0]                 size,
  input  logic                       write,
  input  logic [2*NUM_CS-1:0]        csDevType,
  input  logic [2*NUM_CS-1:0]        csWidth,
  output logic [$clog2(NUM_CS)-1:0]  csIdx,
  output accPlan_t                   plan
);
  localparam int CS_W = $clog2(NUM_CS);

  logic [NUM_CS-1:0] hitCmd, hitAdr, hitDat;

  for (genvar g = 0; g < NUM_CS; g++) begin : gWin
    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(WIN_BASE + g*WIN_STRIDE + CMD_OFS);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(WIN_BASE + g*WIN_STRIDE + ADR_OFS);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(WIN_BASE + g*WIN_STRIDE + DAT_OFS);
    assign hitCmd[g] = (addr[ADDR_W-1:2] == CMD_A[ADDR_W-1:2]);
    assign hitAdr[g] = (addr[ADDR_W-1:2] == ADR_A[ADDR_W-1:2]);
    assign hitDat[g] = (addr[ADDR_W-1:2] == DAT_A[ADDR_W-1:2]);
  end

  regKind_e   kind;
  logic [1:0] devType, devWidth;
  logic       nandOk;

  always_comb begin
    csIdx = '0;
    kind  = REG_NONE;
    for (int i = 0; i < NUM_CS; i++) begin
      if (hitCmd[i] || hitAdr[i] || hitDat[i]) begin
        csIdx = CS_W'(i);
        kind  = hitCmd[i] ? REG_CMD : (hitAdr[i] ? REG_ADR : REG_DAT);
      end
    end
  end

  assign devType  = csDevType[csIdx*2 +: 2];
  assign devWidth = csWidth[csIdx*2 +: 2];
  assign nandOk   = (devType == DEV_NAND) && (devWidth == WID_8 || devWidth == WID_16);

  always_comb begin
    plan.cle  = (kind == REG_CMD);
    plan.ale  = (kind == REG_ADR);
    plan.wide = (devWidth == WID_16);
    if (kind == REG_NONE || !nandOk || (!write && kind != REG_DAT)) begin
      plan.beats = '0;
    end else if (plan.wide) begin
      plan.beats = (size[1]) ? BEAT_CNT_W'(2) : BEAT_CNT_W'(1);
    end else begin
      case (accSize_e'(size))
        SZ_BYTE: plan.beats = BEAT_CNT_W'(1);
        SZ_HALF: plan.beats = BEAT_CNT_W'(2);
        default: plan.beats = BEAT_CNT_W'(4);
      endcase
    end
  end
endmodule

// File: rtl/nwa_ctrl.sv
module nwa_ctrl
  import nwa_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  accPlan_t                  plan,
  input  logic [$clog2(NUM_CS)-1:0] csIdx,
  output logic                      reqReady,
  output logic                      nandValid,
  input  logic                      nandReady,
  output logic [$clog2(NUM_CS)-1:0] nandCs,
  output logic                      nandCle,
  output logic                      nandAle,
  output logic                      nandWrite,
  output logic                      nandWide,
  output dpStrobe_t                 strobe
);
  localparam int CS_W = $clog2(NUM_CS);

  ctrlState_e            state;
  logic [BEAT_IDX_W-1:0] beatIdx, beatLast;
  logic                  cleQ, aleQ, wrQ, wideQ;
  logic [CS_W-1:0]       csQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beatIdx  <= '0;
      beatLast <= '0;
      cleQ     <= 1'b0;
      aleQ     <= 1'b0;
      wrQ      <= 1'b0;
      wideQ    <= 1'b0;
      csQ      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          cleQ     <= plan.cle;
          aleQ     <= plan.ale;
          wrQ      <= reqWrite;
          wideQ    <= plan.wide;
          csQ      <= csIdx;
          beatIdx  <= '0;
          beatLast <= BEAT_IDX_W'(plan.beats - BEAT_CNT_W'(1));
          state    <= (plan.beats == '0) ? ST_DONE : ST_XFER;
        end
        ST_XFER: if (nandReady) begin
          if (beatIdx == beatLast) state <= ST_DONE;
          else beatIdx <= beatIdx + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady  = (state == ST_DONE);
  assign nandValid = (state == ST_XFER);
  assign nandCle   = nandValid & cleQ;
  assign nandAle   = nandValid & aleQ;
  assign nandWrite = wrQ;
  assign nandWide  = wideQ;
  assign nandCs    = csQ;

  assign strobe.load     = (state == ST_IDLE) && reqValid;
  assign strobe.beatDone = nandValid && nandReady;
  assign strobe.wide     = wideQ;
  assign strobe.beatIdx  = beatIdx;

  assert_cle_ale_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    nandValid |-> !(nandCle && nandAle)) else $error("R4: both latch strobes high");

  assert_xfer_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    nandValid && !nandReady |=> nandValid && $stable(nandCs) && $stable(nandCle)
                                && $stable(nandAle) && $stable(nandWrite) && $stable(nandWide))
    else $error("R8: transfer changed while stalled");

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady) else $error("R8: ready longer than one cycle");

  assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) && $past(nandValid) |-> $past(nandReady))
    else $error("R8: completion without final handshake");
endmodule

// File: rtl/nwa_datapath.sv
module nwa_datapath
  import nwa_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BUS_W-1:0]  nandRdata,
  output logic [BUS_W-1:0]  nandWdata,
  output logic [DATA_W-1:0] rspRdata
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = BUS_W;

  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdataQ <= '0;
      rdataQ <= '0;
    end else if (strobe.load) begin
      wdataQ <= reqWdata;
      rdataQ <= '0;
    end else if (strobe.beatDone) begin
      if (strobe.wide) rdataQ[strobe.beatIdx[0]*HALF_W +: HALF_W] <= nandRdata;
      else             rdataQ[strobe.beatIdx*BYTE_W +: BYTE_W]    <= nandRdata[BYTE_W-1:0];
    end
  end

  always_comb begin
    if (strobe.wide) nandWdata = wdataQ[strobe.beatIdx[0]*HALF_W +: HALF_W];
    else             nandWdata = {{(BUS_W-BYTE_W){1'b0}}, wdataQ[strobe.beatIdx*BYTE_W +: BYTE_W]};
  end

  assign rspRdata = rdataQ;

  assert_read_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> rspRdata == '0) else $error("R9: stale read data after new access");
endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
  import nwa_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqSize,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      reqReady,
  output logic [DATA_W-1:0]         rspRdata,
  input  logic [2*NUM_CS-1:0]       csDevType,
  input  logic [2*NUM_CS-1:0]       csWidth,
  output logic                      nandValid,
  input  logic                      nandReady,
  output logic [$clog2(NUM_CS)-1:0] nandCs,
  output logic                      nandCle,
  output logic                      nandAle,
  output logic                      nandWrite,
  output logic                      nandWide,
  output logic [BUS_W-1:0]          nandWdata,
  input  logic [BUS_W-1:0]          nandRdata
);
  localparam int CS_W = $clog2(NUM_CS);

  accPlan_t        plan;
  logic [CS_W-1:0] csIdx;
  dpStrobe_t       strobe;

  nwa_decode #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_decode (
    .addr(reqAddr), .size(reqSize), .write(reqWrite),
    .csDevType(csDevType), .csWidth(csWidth), .csIdx(csIdx), .plan(plan));

  nwa_ctrl #(.NUM_CS(NUM_CS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .plan(plan), .csIdx(csIdx), .reqReady(reqReady), .nandValid(nandValid),
    .nandReady(nandReady), .nandCs(nandCs), .nandCle(nandCle), .nandAle(nandAle),
    .nandWrite(nandWrite), .nandWide(nandWide), .strobe(strobe));

  nwa_datapath #(.BUS_W(BUS_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWdata(reqWdata),
    .nandRdata(nandRdata), .nandWdata(nandWdata), .rspRdata(rspRdata));

  assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    nandValid && !nandReady |=> $stable(nandWdata)) else $error("R8: write data moved while stalled");

  assert_nand_type_R2: assert property (@(posedge clk) disable iff (!rstN)
    nandValid |-> csDevType[nandCs*2 +: 2] == DEV_NAND) else $error("R2: transfer to non-NAND window");

  assert_width_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    nandValid |-> (csWidth[nandCs*2 +: 2] == WID_8 || csWidth[nandCs*2 +: 2] == WID_16))
    else $error("R3: transfer with illegal width");

  assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rstN)
    nandValid && !nandWide |-> nandWdata[BUS_W-1:8] == '0) else $error("R5: upper lane not zero");
endmodule

// File: tb/nand_width_adapter_bench.sv
module nand_width_adapter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic [31:0] rspRdata;
  logic [15:0] csDevType = '0, csWidth = '0;
  logic        nandValid, nandReady = 1'b0;
  logic [2:0]  nandCs;
  logic        nandCle, nandAle, nandWrite, nandWide;
  logic [15:0] nandWdata, nandRdata = '0;

  int  vectors = 0, miscompares = 0;
  bit  finished = 0;
  bit  readyAlways = 1;

  logic        bCle[8], bAle[8], bWr[8], bWide[8];
  logic [2:0]  bCs[8];
  logic [15:0] bWd[8], bRd[8];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_width_adapter u_nand_width_adapter (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .reqReady(reqReady), .rspRdata(rspRdata),
    .csDevType(csDevType), .csWidth(csWidth), .nandValid(nandValid), .nandReady(nandReady),
    .nandCs(nandCs), .nandCle(nandCle), .nandAle(nandAle), .nandWrite(nandWrite),
    .nandWide(nandWide), .nandWdata(nandWdata), .nandRdata(nandRdata));

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // independent address model: window, register kind (0 none,1 cmd,2 adr,3 dat)
  task automatic decodeAddr(input logic [11:0] a, output int cs, output int kind);
    int o;
    cs = 0; kind = 0;
    if (a >= 12'h060 && a < 12'h060 + 8*12'h030) begin
      cs = (int'(a) - 'h60) / 'h30;
      o  = ((int'(a) - 'h60) % 'h30) >> 2;
      kind = (o == 7) ? 1 : (o == 8) ? 2 : (o == 9) ? 3 : 0;
    end
  endtask

  function automatic int expBeats(int kind, bit wr, logic [1:0] dt, logic [1:0] wd, logic [1:0] sz);
    if (kind == 0 || (!wr && kind != 3) || dt != 2'd2 || wd > 2'd1) return 0;
    if (wd == 2'd1) return (sz >= 2) ? 2 : 1;
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic string tagFor(int kind, bit wr, logic [1:0] dt, logic [1:0] wd, logic [1:0] sz);
    if (kind == 0) return "R1";
    if (!wr && kind != 3) return "R9";
    if (dt != 2'd2) return "R2";
    if (wd > 2'd1) return "R3";
    if (wd == 2'd1 && sz == 0) return "R7";
    if (wd == 2'd1) return "R6";
    return "R5";
  endfunction

  task automatic doAccess(input logic [11:0] a, input logic [1:0] sz, input bit wr, input logic [31:0] wd);
    int cs, kind, expN, nb, nCyc;
    logic [1:0] dt, w;
    logic [31:0] got, expR;
    bit done;
    string tg;
    decodeAddr(a, cs, kind);
    dt = csDevType[cs*2 +: 2];
    w  = csWidth[cs*2 +: 2];
    expN = expBeats(kind, wr, dt, w, sz);
    tg = tagFor(kind, wr, dt, w, sz);
    @(negedge clk);
    reqAddr = a; reqSize = sz; reqWrite = wr; reqWdata = wd; reqValid = 1'b1;
    nb = 0; nCyc = 0; done = 0; got = '0;
    while (!done && nCyc < 100) begin
      @(negedge clk);
      nCyc++;
      if (reqReady) begin
        got = rspRdata; done = 1; reqValid = 1'b0;
        check(!nandValid, "R8", "valid at completion", longint'(nandValid), 0);
      end else begin
        nandReady = readyAlways ? 1'b1 : 1'($urandom_range(0, 1));
        nandRdata = 16'($urandom);
        if (nandValid && nandReady && nb < 8) begin
          bCle[nb] = nandCle; bAle[nb] = nandAle; bWr[nb] = nandWrite; bWide[nb] = nandWide;
          bCs[nb] = nandCs; bWd[nb] = nandWdata; bRd[nb] = nandRdata;
          nb++;
        end
      end
    end
    check(done, "R8", "access completed", longint'(done), 1);
    check(nb == expN, tg, "transfer count", nb, expN);
    if (readyAlways) check(nCyc == expN + 1, "R8", "completion latency", nCyc, expN + 1);
    expR = '0;
    for (int i = 0; i < nb && i < expN; i++) begin
      check(bCle[i] == (kind == 1), "R4", "cle", longint'(bCle[i]), longint'(kind == 1));
      check(bAle[i] == (kind == 2), "R4", "ale", longint'(bAle[i]), longint'(kind == 2));
      check(bCs[i] == 3'(cs), "R10", "chip select", bCs[i], cs);
      check(bWr[i] == wr, "R10", "direction", longint'(bWr[i]), longint'(wr));
      check(bWide[i] == (w == 2'd1), "R10", "wide flag", longint'(bWide[i]), longint'(w == 2'd1));
      if (wr) begin
        if (w == 2'd1) check(bWd[i] == wd[16*i +: 16], tg, "halfword out", bWd[i], wd[16*i +: 16]);
        else check(bWd[i] == {8'h00, wd[8*i +: 8]}, tg, "byte out", bWd[i], wd[8*i +: 8]);
      end
      if (w == 2'd1) expR[16*i +: 16] = bRd[i];
      else expR[8*i +: 8] = bRd[i][7:0];
    end
    if (!wr) check(got == expR, tg, "read data", got, expR);
  endtask

  task automatic setWin(input int cs, input logic [1:0] dt, input logic [1:0] w);
    csDevType[cs*2 +: 2] = dt;
    csWidth[cs*2 +: 2]   = w;
  endtask

  function automatic logic [11:0] regAddr(input int cs, input int kind);
    return 12'(32'h60 + cs*32'h30 + 32'h1C + 4*(kind - 1));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check(!reqReady, "R8", "reset ready", longint'(reqReady), 0);
    check(!nandValid, "R8", "reset valid", longint'(nandValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!reqReady && !nandValid, "R8", "idle after reset", longint'(reqReady | nandValid), 0);

    // directed corner cases, ready always high
    setWin(3, 2'd2, 2'd0);
    doAccess(regAddr(3, 1), 2'd2, 1'b1, 32'hA1B2C3D4);    // R4/R5 command, four bytes
    setWin(7, 2'd2, 2'd1);
    doAccess(regAddr(7, 3), 2'd2, 1'b0, 32'h0);           // R6 word read, two halves
    setWin(0, 2'd2, 2'd1);
    doAccess(regAddr(0, 3) + 12'd1, 2'd0, 1'b0, 32'h0);   // R7 byte read, low bits ignored (R1)
    doAccess(regAddr(0, 3), 2'd0, 1'b1, 32'h0000BEEF);    // R7 byte write to wide device
    setWin(5, 2'd2, 2'd0);
    doAccess(regAddr(5, 3), 2'd1, 1'b0, 32'h0);           // R5 halfword read, two bytes
    setWin(2, 2'd2, 2'd1);
    doAccess(regAddr(2, 2), 2'd1, 1'b1, 32'h00001234);    // R4 address write, ale
    setWin(4, 2'd0, 2'd0);
    doAccess(regAddr(4, 3), 2'd2, 1'b1, 32'h55AA55AA);    // R2 dropped write
    doAccess(regAddr(4, 3), 2'd2, 1'b0, 32'h0);           // R2 zero read
    setWin(6, 2'd2, 2'd2);
    doAccess(regAddr(6, 3), 2'd2, 1'b0, 32'h0);           // R3 illegal width
    setWin(1, 2'd2, 2'd0);
    doAccess(regAddr(1, 1), 2'd2, 1'b0, 32'h0);           // R9 command read
    doAccess(regAddr(1, 2), 2'd2, 1'b0, 32'h0);           // R9 address read
    doAccess(12'h204, 2'd2, 1'b0, 32'h0);                 // R1 beyond last window
    doAccess(12'h05C, 2'd2, 1'b1, 32'hFFFFFFFF);          // R1 below first window
    doAccess(regAddr(1, 3) + 12'h4, 2'd2, 1'b0, 32'h0);   // R1 gap inside window

    // constrained random, random device stalls
    readyAlways = 0;
    for (int n = 0; n < 400; n++) begin
      int cs, kind;
      logic [11:0] a;
      for (int c = 0; c < 8; c++) begin
        setWin(c, ($urandom_range(0, 9) < 7) ? 2'd2 : 2'($urandom),
                  ($urandom_range(0, 9) < 8) ? 2'($urandom_range(0, 1)) : 2'($urandom));
      end
      cs = $urandom_range(0, 7);
      kind = $urandom_range(1, 3);
      a = ($urandom_range(0, 9) == 0) ? 12'($urandom) : regAddr(cs, kind) + 12'($urandom_range(0, 3));
      doAccess(a, 2'($urandom), 1'($urandom), $urandom);
      if (n == 200) readyAlways = 1;
      if (n == 300) readyAlways = 0;
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule